// File: doc/BRIEF.md
# Two-Wire 16-Bit Register Target

This block is the target side of a two-wire serial bus. It lets an outside controller read and write a bank of 16-bit registers that lives elsewhere on the chip. The registers are selected by an 8-bit pointer. The clock and data lines are sampled by a fast system clock. The block finds start and stop conditions and answers one fixed 7-bit device address. It acknowledges bytes and shifts out read data by pulling the data line low through an open-drain enable. It never drives the line high.

A write carries a pointer byte and then any number of byte pairs. Each pair holds the high byte first and becomes one register write. After each complete pair the pointer steps to the next register. A read first sets the pointer with a write-mode header. It then sends a repeated start and the read-mode address, and the block streams register words high byte first. The pointer survives repeated starts and stops, so a read-mode header alone continues from the last pointer. The register bank itself sits outside the block. The block presents a one-cycle write strobe with address and data, plus a read address whose word must come back in the same cycle.

Top module: `twire_reg16_target`

## Requirements
- R1: After reset the data pull enable is low, the write strobe is low and the read address (register pointer) is 0x00.
- R2: The block reacts only after a start: a falling data line while the clock is high. A rising data line while the clock is high is a stop, and it leaves the block idle with the data line released. A header byte sent with no start before it is not acknowledged.
- R3: The first byte after a start is the device address in bits 7..1 (default 0x5D) and the direction in bit 0 (0 = write, 1 = read), so 0xBA writes and 0xBB reads. A matching byte is acknowledged by pulling data low during the ninth clock pulse.
- R4: A header byte with any other address is not acknowledged. Until the next start the block drives nothing, writes nothing and keeps its pointer.
- R5: In a write, the byte after the header loads the pointer, and every following byte is acknowledged. Each pair of data bytes, high byte first, produces exactly one single-cycle write strobe carrying the pointer and the 16-bit value.
- R6: The pointer advances by one after each complete 16-bit word and wraps from 0xFF to 0x00.
- R7: If a stop or a repeated start arrives after only the high byte of a pair, no register is written.
- R8: After a repeated start and the read header, the block shifts out the word at the pointer, high byte first and MSB first, and keeps sending following words while the controller acknowledges.
- R9: A no-acknowledge from the controller ends a read: the block releases the line and goes idle. The pointer advances only after the low byte of a word has been sent. The pointer is kept across starts and stops, so a read-only transaction resumes at it.
- R10: The data pull enable changes only after a falling clock edge or a start/stop, never in the middle of a clock-high period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | Open-drain enable: 1 pulls the data line low |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 8 | Register index for the write |
| reg_wr_data | output | 16 | Value to write |
| reg_rd_addr | output | 8 | Current register pointer, used as read index |
| reg_rd_data | input | 16 | Word at reg_rd_addr, valid in the same cycle |

## Verification
The assertions take for granted that the controller moves the data line only while the clock is low, except for start and stop. They also assume each bus clock phase lasts longer than the synchroniser delay plus a cycle, and that the controller never issues a start while the target is pulling data low. The stimulus builds every bus event from quarter-bit steps of six system cycles. Data changes in the low quarter, and start and stop are made only with the clock high and the line released. Under those conditions, the pull enable moving or the pointer stepping outside the allowed instants points to a fault in the block.

// File: rtl/twire_pkg.sv
package twire_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int PTR_W  = 8;
    localparam int DEV_W  = 7;
    localparam int CNT_W  = 4;

    // bit counter marks: data bits end at 8, acknowledge slot is 9
    localparam logic [CNT_W-1:0] CNT_BYTE_END = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_ACK_SLOT = CNT_W'(BYTE_W + 1);

    typedef enum logic [1:0] {
        ROLE_ADDR,
        ROLE_PTR,
        ROLE_WDATA,
        ROLE_RDATA
    } role_e;

    typedef enum logic {
        PH_IDLE,
        PH_BUSY
    } phase_e;

    typedef struct packed {
        logic [PTR_W-1:0]  addr;
        logic [WORD_W-1:0] data;
    } wr_req_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] hdr,
                                      input logic [DEV_W-1:0]  dev);
        return hdr[BYTE_W-1:1] == dev;
    endfunction

endpackage

// File: rtl/twire_line_sync.sv
module twire_line_sync #(
    parameter int STAGES   = 2,
    parameter bit IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    if (STAGES == 1) begin : g_one
        always_ff @(posedge clk) begin
            if (rst) chain <= IDLE_VAL;
            else     chain <= din;
        end
    end else begin : g_many
        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{IDLE_VAL}};
            else     chain <= {chain[STAGES-2:0], din};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= IDLE_VAL;
        else     prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev;
    assign fall  = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/twire_cond_detect.sv
module twire_cond_detect (
    input  logic scl_lvl,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_ev,
    output logic stop_ev
);
    // both lines pass through equal-length synchronisers, so a data
    // edge seen with the clock level high is a bus condition
    assign start_ev = scl_lvl & sda_fall;
    assign stop_ev  = scl_lvl & sda_rise;

endmodule

// File: rtl/twire_target_fsm.sv
module twire_target_fsm
    import twire_pkg::*;
#(
    parameter logic [DEV_W-1:0] DEV_ADDR = 7'h5D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic [WORD_W-1:0] rd_word,
    output logic [PTR_W-1:0]  ptr,
    output logic              oe,
    output logic              wr_en,
    output wr_req_t           wr_req
);
    phase_e             phase;
    role_e              role;
    logic [CNT_W-1:0]   bit_cnt;
    logic [BYTE_W-1:0]  shreg;
    logic [BYTE_W-1:0]  hold;
    logic [BYTE_W-1:0]  nxt_byte;
    logic               half;
    logic               rw;
    logic               mack;

    // next byte to transmit: high byte fresh from the bank, or the stored low byte
    always_comb nxt_byte = half ? hold : rd_word[WORD_W-1:BYTE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            role    <= ROLE_ADDR;
            bit_cnt <= '0;
            shreg   <= '0;
            hold    <= '0;
            half    <= 1'b0;
            rw      <= 1'b0;
            mack    <= 1'b0;
            oe      <= 1'b0;
            ptr     <= '0;
            wr_en   <= 1'b0;
            wr_req  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_ev) begin
                phase   <= PH_BUSY;
                role    <= ROLE_ADDR;
                bit_cnt <= '0;
                half    <= 1'b0;
                oe      <= 1'b0;
            end else if (stop_ev) begin
                phase   <= PH_IDLE;
                bit_cnt <= '0;
                half    <= 1'b0;
                oe      <= 1'b0;
            end else if (phase == PH_BUSY) begin
                if (scl_rise) begin
                    if (bit_cnt < CNT_BYTE_END) begin
                        bit_cnt <= bit_cnt + 1'b1;
                        if (role != ROLE_RDATA)
                            shreg <= {shreg[BYTE_W-2:0], sda_lvl};
                    end else if (bit_cnt == CNT_ACK_SLOT && role == ROLE_RDATA) begin
                        mack <= ~sda_lvl;
                    end
                end else if (scl_fall) begin
                    if (role == ROLE_RDATA && bit_cnt != '0 && bit_cnt < CNT_BYTE_END) begin
                        shreg <= {shreg[BYTE_W-2:0], 1'b0};
                        oe    <= ~shreg[BYTE_W-2];
                    end else if (bit_cnt == CNT_BYTE_END) begin
                        bit_cnt <= CNT_ACK_SLOT;
                        case (role)
                            ROLE_ADDR: begin
                                if (addr_hit(shreg, DEV_ADDR)) begin
                                    oe <= 1'b1;
                                    rw <= shreg[0];
                                end else begin
                                    oe    <= 1'b0;
                                    phase <= PH_IDLE;
                                end
                            end
                            ROLE_PTR: begin
                                oe   <= 1'b1;
                                ptr  <= shreg;
                                half <= 1'b0;
                            end
                            ROLE_WDATA: begin
                                oe <= 1'b1;
                                if (!half) begin
                                    hold <= shreg;
                                    half <= 1'b1;
                                end else begin
                                    wr_en       <= 1'b1;
                                    wr_req.addr <= ptr;
                                    wr_req.data <= {hold, shreg};
                                    ptr         <= ptr + 1'b1;
                                    half        <= 1'b0;
                                end
                            end
                            default: begin
                                // release for the controller's acknowledge
                                oe <= 1'b0;
                                if (!half) ptr <= ptr + 1'b1;
                            end
                        endcase
                    end else if (bit_cnt == CNT_ACK_SLOT) begin
                        bit_cnt <= '0;
                        case (role)
                            ROLE_ADDR: begin
                                if (rw) begin
                                    role  <= ROLE_RDATA;
                                    shreg <= nxt_byte;
                                    oe    <= ~nxt_byte[BYTE_W-1];
                                    half  <= ~half;
                                    if (!half) hold <= rd_word[BYTE_W-1:0];
                                end else begin
                                    role <= ROLE_PTR;
                                    oe   <= 1'b0;
                                end
                            end
                            ROLE_PTR: begin
                                role <= ROLE_WDATA;
                                oe   <= 1'b0;
                            end
                            ROLE_WDATA: oe <= 1'b0;
                            default: begin
                                if (mack) begin
                                    shreg <= nxt_byte;
                                    oe    <= ~nxt_byte[BYTE_W-1];
                                    half  <= ~half;
                                    if (!half) hold <= rd_word[BYTE_W-1:0];
                                end else begin
                                    phase <= PH_IDLE;
                                    oe    <= 1'b0;
                                end
                            end
                        endcase
                    end
                end
            end
        end
    end

    // R10: the pull enable moves only in response to a clock fall or a bus condition
    a_r10_oe_moves_on_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(oe) |-> ($past(scl_fall) || $past(start_ev) || $past(stop_ev)));

    // R5: every register write is a single-cycle strobe
    a_r5_strobe_single: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R6: the pointer already points past the word being written
    a_r6_ptr_after_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (ptr == PTR_W'(wr_req.addr + 1'b1)));

    // R4: nothing is driven while the block ignores the bus
    a_r4_idle_released: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> !oe);

    // R9: a controller no-acknowledge frees the line and ends the read
    a_r9_nack_frees: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_BUSY && role == ROLE_RDATA && bit_cnt == CNT_ACK_SLOT &&
         scl_fall && !start_ev && !stop_ev && !mack)
        |=> (phase == PH_IDLE && !oe));

endmodule

// File: rtl/twire_reg16_target.sv
module twire_reg16_target
    import twire_pkg::*;
#(
    parameter logic [DEV_W-1:0] DEV_ADDR    = 7'h5D,
    parameter int               SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    output logic              reg_wr_en,
    output logic [PTR_W-1:0]  reg_wr_addr,
    output logic [WORD_W-1:0] reg_wr_data,
    output logic [PTR_W-1:0]  reg_rd_addr,
    input  logic [WORD_W-1:0] reg_rd_data
);
    logic    scl_lvl, scl_rise, scl_fall;
    logic    sda_lvl, sda_rise, sda_fall;
    logic    start_ev, stop_ev;
    wr_req_t wr_req;

    twire_line_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_scl_sync (
        .clk   (clk),
        .rst   (rst),
        .din   (scl_in),
        .level (scl_lvl),
        .rise  (scl_rise),
        .fall  (scl_fall)
    );

    twire_line_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sda_sync (
        .clk   (clk),
        .rst   (rst),
        .din   (sda_in),
        .level (sda_lvl),
        .rise  (sda_rise),
        .fall  (sda_fall)
    );

    twire_cond_detect u_cond (
        .scl_lvl  (scl_lvl),
        .sda_rise (sda_rise),
        .sda_fall (sda_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    twire_target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_lvl  (sda_lvl),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .rd_word  (reg_rd_data),
        .ptr      (reg_rd_addr),
        .oe       (sda_pull),
        .wr_en    (reg_wr_en),
        .wr_req   (wr_req)
    );

    assign reg_wr_addr = wr_req.addr;
    assign reg_wr_data = wr_req.data;

endmodule

// File: tb/twire_reg16_target_tb.sv
module twire_reg16_target_tb;

    localparam int Q = 6;   // system cycles per quarter bit

    logic        clk = 1'b0;
    logic        rst;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_bus;
    logic        sda_pull;
    logic        reg_wr_en;
    logic [7:0]  reg_wr_addr;
    logic [15:0] reg_wr_data;
    logic [7:0]  reg_rd_addr;
    logic [15:0] reg_rd_data;

    logic [15:0] bank  [256];
    logic [15:0] model [256];
    logic [15:0] wbuf  [4];

    int total = 0;
    int bad   = 0;
    int glitch = 0;
    logic prev_pull = 1'b0;
    logic prev_scl  = 1'b1;

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;

    twire_reg16_target u_dut (
        .clk         (clk),
        .rst         (rst),
        .scl_in      (scl_m),
        .sda_in      (sda_bus),
        .sda_pull    (sda_pull),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_addr (reg_wr_addr),
        .reg_wr_data (reg_wr_data),
        .reg_rd_addr (reg_rd_addr),
        .reg_rd_data (reg_rd_data)
    );

    // register bank owned by the surrounding logic
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) bank[i] <= 16'h0000;
        end else if (reg_wr_en) begin
            bank[reg_wr_addr] <= reg_wr_data;
        end
    end
    assign reg_rd_data = bank[reg_rd_addr];

    // R10 monitor: pull enable must hold still while the clock stays high
    always @(negedge clk) begin
        if (!rst && scl_m && prev_scl && (sda_pull != prev_pull)) glitch++;
        prev_pull <= sda_pull;
        prev_scl  <= scl_m;
    end

    function automatic logic [7:0] step_ptr(input logic [7:0] p, input int k);
        return 8'(p + k);
    endfunction

    function automatic logic [7:0] hdr_byte(input logic rd);
        return {7'h5D, rd};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_bus;  tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = ~b;
    endtask

    task automatic get_byte(input logic ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~ack);
    endtask

    task automatic write_words(input logic [7:0] p, input int n);
        logic ak;
        bus_start();
        put_byte(hdr_byte(1'b0), ak);
        check(ak, "R3 write header ack", 32'(ak), 1);
        put_byte(p, ak);
        check(ak, "R5 pointer byte ack", 32'(ak), 1);
        for (int k = 0; k < n; k++) begin
            put_byte(wbuf[k][15:8], ak);
            check(ak, "R5 high byte ack", 32'(ak), 1);
            put_byte(wbuf[k][7:0], ak);
            check(ak, "R5 low byte ack", 32'(ak), 1);
            model[step_ptr(p, k)] = wbuf[k];
        end
        bus_stop();
        tick(2);
        for (int k = 0; k < n; k++)
            check(bank[step_ptr(p, k)] == model[step_ptr(p, k)], "R5 register written",
                  32'(bank[step_ptr(p, k)]), 32'(model[step_ptr(p, k)]));
        check(reg_rd_addr == step_ptr(p, n), "R6 pointer after write",
              32'(reg_rd_addr), 32'(step_ptr(p, n)));
    endtask

    task automatic read_words(input logic [7:0] p, input int n);
        logic ak;
        logic [7:0] hi, lo;
        bus_start();
        put_byte(hdr_byte(1'b0), ak);
        check(ak, "R3 write header ack", 32'(ak), 1);
        put_byte(p, ak);
        check(ak, "R5 pointer byte ack", 32'(ak), 1);
        bus_start();
        put_byte(hdr_byte(1'b1), ak);
        check(ak, "R3 read header ack", 32'(ak), 1);
        for (int k = 0; k < n; k++) begin
            get_byte(1'b1, hi);
            get_byte(k != n - 1, lo);
            check({hi, lo} == model[step_ptr(p, k)], "R8 read word",
                  32'({hi, lo}), 32'(model[step_ptr(p, k)]));
        end
        bus_stop();
        tick(2);
        check(reg_rd_addr == step_ptr(p, n), "R9 pointer after read",
              32'(reg_rd_addr), 32'(step_ptr(p, n)));
        check(sda_pull == 1'b0, "R9 line released after nack", 32'(sda_pull), 0);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic ak;
        logic [7:0] hi, lo, keep_ptr;
        logic [15:0] keep_word;
        void'($urandom(32'd7351));
        for (int i = 0; i < 256; i++) model[i] = 16'h0000;

        rst = 1'b1;
        tick(5);
        rst = 1'b0;
        tick(2);

        // R1 reset state
        check(sda_pull == 1'b0, "R1 pull low after reset", 32'(sda_pull), 0);
        check(reg_wr_en == 1'b0, "R1 strobe low after reset", 32'(reg_wr_en), 0);
        check(reg_rd_addr == 8'h00, "R1 pointer zero after reset", 32'(reg_rd_addr), 0);

        // R5/R6 plain write, R8 read back through repeated start
        wbuf[0] = 16'hA55A;
        wbuf[1] = 16'h1234;
        write_words(8'h10, 2);
        read_words(8'h10, 2);

        // R6 wrap from 0xFF to 0x00
        wbuf[0] = 16'hBEEF;
        wbuf[1] = 16'hC0DE;
        write_words(8'hFF, 2);
        check(bank[8'h00] == 16'hC0DE, "R6 wrapped word lands at 0x00",
              32'(bank[8'h00]), 32'h0000C0DE);
        read_words(8'hFF, 2);

        // R4 foreign address: no ack, nothing driven, nothing written
        keep_ptr = reg_rd_addr;
        bus_start();
        put_byte(8'hBC, ak);
        check(!ak, "R4 foreign header not acked", 32'(ak), 0);
        put_byte(8'h20, ak);
        check(!ak, "R4 ignored byte not acked", 32'(ak), 0);
        put_byte(8'hFF, ak);
        check(!ak, "R4 ignored byte not acked", 32'(ak), 0);
        put_byte(8'hFF, ak);
        bus_stop();
        tick(2);
        check(bank[8'h20] == model[8'h20], "R4 no write after foreign header",
              32'(bank[8'h20]), 32'(model[8'h20]));
        check(reg_rd_addr == keep_ptr, "R4 pointer kept", 32'(reg_rd_addr), 32'(keep_ptr));

        // R2 header without a start is ignored
        put_byte(hdr_byte(1'b0), ak);
        check(!ak, "R2 header without start not acked", 32'(ak), 0);
        tick(2);
        check(sda_pull == 1'b0, "R2 line released while idle", 32'(sda_pull), 0);

        // R7 half pair dropped on stop
        model[8'h30] = 16'h0000;
        bus_start();
        put_byte(hdr_byte(1'b0), ak);
        put_byte(8'h30, ak);
        put_byte(8'h77, ak);
        check(ak, "R5 lone high byte acked", 32'(ak), 1);
        bus_stop();
        tick(2);
        check(bank[8'h30] == model[8'h30], "R7 half pair dropped on stop",
              32'(bank[8'h30]), 32'(model[8'h30]));

        // R7 half pair dropped on repeated start, then a fresh pair
        bus_start();
        put_byte(hdr_byte(1'b0), ak);
        put_byte(8'h31, ak);
        put_byte(8'h11, ak);
        bus_start();
        put_byte(hdr_byte(1'b0), ak);
        put_byte(8'h32, ak);
        put_byte(8'h9A, ak);
        put_byte(8'hBC, ak);
        bus_stop();
        tick(2);
        model[8'h32] = 16'h9ABC;
        check(bank[8'h31] == model[8'h31], "R7 half pair dropped on repeated start",
              32'(bank[8'h31]), 32'(model[8'h31]));
        check(bank[8'h32] == 16'h9ABC, "R7 following pair written",
              32'(bank[8'h32]), 32'h00009ABC);

        // R9 nack after the high byte: pointer does not advance
        keep_word = model[8'h10];
        bus_start();
        put_byte(hdr_byte(1'b0), ak);
        put_byte(8'h10, ak);
        bus_start();
        put_byte(hdr_byte(1'b1), ak);
        get_byte(1'b0, hi);
        bus_stop();
        tick(2);
        check(hi == keep_word[15:8], "R8 high byte first", 32'(hi), 32'(keep_word[15:8]));
        check(reg_rd_addr == 8'h10, "R9 no advance after half word",
              32'(reg_rd_addr), 32'h10);
        check(sda_pull == 1'b0, "R9 released after nack", 32'(sda_pull), 0);

        // R9 read-only transaction resumes at the kept pointer
        bus_start();
        put_byte(hdr_byte(1'b1), ak);
        check(ak, "R3 read header ack", 32'(ak), 1);
        get_byte(1'b1, hi);
        get_byte(1'b0, lo);
        bus_stop();
        tick(2);
        check({hi, lo} == keep_word, "R9 resume at kept pointer",
              32'({hi, lo}), 32'(keep_word));
        check(reg_rd_addr == 8'h11, "R9 advance after full word",
              32'(reg_rd_addr), 32'h11);

        // constrained random write/read pairs
        for (int t = 0; t < 10; t++) begin
            logic [7:0] p;
            int n;
            p = 8'($urandom_range(0, 255));
            n = int'($urandom_range(1, 3));
            for (int k = 0; k < n; k++) wbuf[k] = 16'($urandom());
            write_words(p, n);
            read_words(p, n);
        end

        check(glitch == 0, "R10 pull stable while clock high", 32'(glitch), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule